// File: doc/BRIEF.md
# Multi-Output Level Interrupt Aggregator

This block collects level-sensitive interrupt lines, grouped into words of 32 sources each, and concentrates them onto a small set of parent interrupt lines. Software programs one enable register per word over a simple register port. It can read the live source levels through a read-only status register per word. A source takes part only while its level is high and its enable bit is 1. Each parent line has its own fixed routing mask per word, set at build time. That mask chooses which sources may drive that parent.

Interrupts are not acknowledged or cleared. A parent line stays high until every selected source drops or is masked. For low-power operation, a suspend input widens the enable set by ORing in a per-word wake-enable register. The stored enable value is left untouched, so normal masking returns as soon as suspend falls. Sources that no routing mask selects are inert: they can never raise a parent line, and they cannot be marked as wake sources.

The register port is a plain single-cycle write strobe with a combinational read path. There is no back-pressure: a write is taken on the clock edge where `reg_we` is high, and read data is valid in the same cycle as the address.

Top module: `irq_fanin_agg`

## Requirements
- R1: On reset, each word's enable register takes the value of that word's slice of the FWD_MASK parameter, every wake-enable register is cleared, and all parent outputs go low.
- R2: Byte address 8*n reaches word n's enable register and 8*n+4 reaches its read-only status register. Address 0x20+4*n reaches word n's wake-enable register. Every other address, including a misaligned one or one for a word at or above NWORDS, reads as zero and ignores writes.
- R3: A status register always reads the current source levels of its word. Writing to a status address changes nothing.
- R4: A source is pending only when its level and its effective enable bit are both 1. The parent outputs are registered, so they reflect the pending set one clock edge after a source or register change.
- R5: Parent p is high exactly when, in some word, a pending source lies inside parent p's routing mask for that word. The mask for parent p, word w is ROUTE[(p*NWORDS+w)*32 +: 32].
- R6: A source bit that appears in no parent's routing mask never raises any parent output, whatever its enable or wake bits hold.
- R7: A write to a wake-enable register stores only the bits of used sources; bits of unused sources read back as 0.
- R8: While `suspend` is 1, each word's effective enable is its stored enable OR its wake-enable. The enable register reads back its stored value throughout. After `suspend` returns to 0, the stored enable alone applies again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| suspend | input | 1 | Low-power mode: ORs wake-enable into the enable set |
| reg_addr | input | 6 | Byte address of the register access |
| reg_we | input | 1 | Write strobe, taken on the rising clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| src_level | input | NWORDS*32 | Live source levels; bit 32*w+b is source b of word w |
| parent_irq | output | NPARENT | Registered parent interrupt lines |

## Verification
Masking and the suspend widening act on the same source in the same cycle. The bench raises a source whose enable bit is 0 but whose wake bit is 1. It then toggles `suspend` around that source and judges the parent output one edge later against the OR of the two sets, with the enable readback held fixed. A second coincidence involves an unused source held high with every enable and wake bit set while suspend is active. No parent output may move in that case.

// File: rtl/ifa_pkg.sv
package ifa_pkg;
  localparam int WORD_W    = 32;
  localparam int ADDR_W    = 6;
  localparam int MAX_WORDS = 4;

  typedef enum logic [1:0] {RK_NONE, RK_EN, RK_STAT, RK_WAKE} reg_kind_e;

  typedef struct packed {
    reg_kind_e  kind;
    logic [1:0] idx;
  } reg_sel_t;

  // Map a byte address onto a register kind and word index.
  function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a, input int nwords);
    reg_sel_t s;
    s.kind = RK_NONE;
    s.idx  = 2'd0;
    if (a[1:0] == 2'b00) begin
      if (!a[5]) begin
        s.idx = a[4:3];
        if (int'(a[4:3]) < nwords) s.kind = a[2] ? RK_STAT : RK_EN;
      end else if (!a[4]) begin
        s.idx = a[3:2];
        if (int'(a[3:2]) < nwords) s.kind = RK_WAKE;
      end
    end
    return s;
  endfunction
endpackage

// File: rtl/ifa_regfile.sv
module ifa_regfile
  import ifa_pkg::*;
#(
  parameter int NWORDS = 2,
  parameter logic [NWORDS*WORD_W-1:0] USED = '1,
  parameter logic [NWORDS*WORD_W-1:0] FWD  = '0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     suspend,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic                     reg_we,
  input  logic [WORD_W-1:0]        reg_wdata,
  input  logic [NWORDS*WORD_W-1:0] src_level,
  output logic [WORD_W-1:0]        reg_rdata,
  output logic [NWORDS*WORD_W-1:0] eff_en
);
  reg_sel_t sel;
  logic [NWORDS-1:0][WORD_W-1:0] en_q;
  logic [NWORDS-1:0][WORD_W-1:0] wk_q;

  assign sel = decode_addr(reg_addr, NWORDS);

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    localparam logic [WORD_W-1:0] USED_W = USED[w*WORD_W +: WORD_W];
    localparam logic [WORD_W-1:0] FWD_W  = FWD[w*WORD_W +: WORD_W];
    logic hit_en, hit_wk;
    assign hit_en = reg_we && (sel.kind == RK_EN)   && (sel.idx == 2'(w));
    assign hit_wk = reg_we && (sel.kind == RK_WAKE) && (sel.idx == 2'(w));

    always_ff @(posedge clk) begin
      if (rst) begin
        en_q[w] <= FWD_W;
        wk_q[w] <= '0;
      end else begin
        if (hit_en) en_q[w] <= reg_wdata;
        if (hit_wk) wk_q[w] <= reg_wdata & USED_W;
      end
    end

    assign eff_en[w*WORD_W +: WORD_W] = en_q[w] | (suspend ? wk_q[w] : '0);

    assert_reset_fwd_R1: assert property (@(posedge clk)
      $past(rst) |-> (en_q[w] == FWD_W && wk_q[w] == '0));
    assert_wake_used_R7: assert property (@(posedge clk) disable iff (rst)
      (wk_q[w] & ~USED_W) == '0);
    assert_en_hold_R8: assert property (@(posedge clk) disable iff (rst)
      (suspend && !hit_en) |=> $stable(en_q[w]));
  end

  always_comb begin
    reg_rdata = '0;
    for (int w = 0; w < NWORDS; w++) begin
      if (sel.idx == 2'(w)) begin
        case (sel.kind)
          RK_EN:   reg_rdata = en_q[w];
          RK_STAT: reg_rdata = src_level[w*WORD_W +: WORD_W];
          RK_WAKE: reg_rdata = wk_q[w];
          default: reg_rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/ifa_router.sv
module ifa_router
  import ifa_pkg::*;
#(
  parameter int NWORDS  = 2,
  parameter int NPARENT = 2,
  parameter logic [NPARENT*NWORDS*WORD_W-1:0] ROUTE = '1,
  parameter logic [NWORDS*WORD_W-1:0] USED = '1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NWORDS*WORD_W-1:0] src_level,
  input  logic [NWORDS*WORD_W-1:0] eff_en,
  output logic [NPARENT-1:0]       parent_irq
);
  localparam int SRC_W = NWORDS * WORD_W;

  logic [SRC_W-1:0]   pending;
  logic [NPARENT-1:0] hit;

  assign pending = src_level & eff_en;

  for (genvar p = 0; p < NPARENT; p++) begin : g_parent
    localparam logic [SRC_W-1:0] RMASK = ROUTE[p*SRC_W +: SRC_W];
    assign hit[p] = |(pending & RMASK);

    assert_route_on_R5: assert property (@(posedge clk) disable iff (rst)
      (|(src_level & eff_en & RMASK)) |=> parent_irq[p]);
    assert_route_off_R4: assert property (@(posedge clk) disable iff (rst)
      !(|(src_level & eff_en & RMASK)) |=> !parent_irq[p]);
  end

  always_ff @(posedge clk) begin
    if (rst) parent_irq <= '0;
    else     parent_irq <= hit;
  end

  assert_unused_inert_R6: assert property (@(posedge clk) disable iff (rst)
    !(|(src_level & eff_en & USED)) |=> (parent_irq == '0));
endmodule

// File: rtl/irq_fanin_agg.sv
module irq_fanin_agg
  import ifa_pkg::*;
#(
  parameter int NWORDS  = 2,
  parameter int NPARENT = 2,
  parameter logic [NWORDS*32-1:0] FWD_MASK = {32'h0000_0000, 32'h0000_000F},
  parameter logic [NPARENT*NWORDS*32-1:0] ROUTE =
    {32'h0000_FF00, 32'hFFFF_0000, 32'h0000_00FF, 32'h0000_FFFF}
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   suspend,
  input  logic [5:0]             reg_addr,
  input  logic                   reg_we,
  input  logic [31:0]            reg_wdata,
  output logic [31:0]            reg_rdata,
  input  logic [NWORDS*32-1:0]   src_level,
  output logic [NPARENT-1:0]     parent_irq
);
  localparam int SRC_W = NWORDS * WORD_W;

  function automatic logic [SRC_W-1:0] calc_used();
    logic [SRC_W-1:0] u = '0;
    for (int p = 0; p < NPARENT; p++) u |= ROUTE[p*SRC_W +: SRC_W];
    return u;
  endfunction

  localparam logic [SRC_W-1:0] USED = calc_used();

  logic [SRC_W-1:0] eff_en;

  ifa_regfile #(.NWORDS(NWORDS), .USED(USED), .FWD(FWD_MASK)) u_regs (
    .clk(clk), .rst(rst), .suspend(suspend),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .src_level(src_level), .reg_rdata(reg_rdata), .eff_en(eff_en)
  );

  ifa_router #(.NWORDS(NWORDS), .NPARENT(NPARENT), .ROUTE(ROUTE), .USED(USED)) u_route (
    .clk(clk), .rst(rst), .src_level(src_level), .eff_en(eff_en),
    .parent_irq(parent_irq)
  );
endmodule

// File: tb/sim_irq_fanin_agg.sv
module sim_irq_fanin_agg;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        suspend = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [63:0] src_level = '0;
  logic [1:0]  parent_irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_fanin_agg u0 (
    .clk(clk), .rst(rst), .suspend(suspend), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .src_level(src_level), .parent_irq(parent_irq)
  );

  // {src word1, src word0, suspend, expected parents, requirement number}
  typedef struct packed {
    logic [31:0] w1;
    logic [31:0] w0;
    logic        susp;
    logic [1:0]  exp;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{32'h0,          32'h0,          1'b0, 2'b00, 4'd4}, // R4 idle
    '{32'h0,          32'h0000_0001,  1'b0, 2'b01, 4'd5}, // R5 parent0
    '{32'h0,          32'h0001_0000,  1'b0, 2'b10, 4'd5}, // R5 parent1
    '{32'h0,          32'h0000_0002,  1'b0, 2'b00, 4'd4}, // R4 masked
    '{32'h0001_0000,  32'h0,          1'b0, 2'b00, 4'd6}, // R6 unused bit
    '{32'h0000_0100,  32'h0,          1'b0, 2'b10, 4'd5}, // R5 word1 p1
    '{32'h0000_0001,  32'h0,          1'b0, 2'b01, 4'd5}, // R5 word1 p0
    '{32'h0,          32'h0001_0001,  1'b0, 2'b11, 4'd5}, // R5 both
    '{32'h0,          32'h0000_0002,  1'b1, 2'b01, 4'd8}, // R8 wake widens
    '{32'h0,          32'h0000_0002,  1'b0, 2'b00, 4'd8}, // R8 restore
    '{32'hFFFF_0000,  32'h0,          1'b1, 2'b00, 4'd6}, // R6 unused under suspend
    '{32'h0,          32'h8000_0000,  1'b1, 2'b00, 4'd8}  // R8 no wake bit
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [1:0]  prev;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    check("R1 parents", 32'(parent_irq), 32'h0);
    rd(6'h00, d); check("R1 en0", d, 32'h0000_000F);
    rd(6'h08, d); check("R1 en1", d, 32'h0);
    rd(6'h20, d); check("R1 wake0", d, 32'h0);

    // R2 map and setup
    wr(6'h00, 32'h0001_0001);
    wr(6'h08, 32'hFFFF_FFFF);
    wr(6'h20, 32'h0000_0002);
    wr(6'h24, 32'hFFFF_FFFF);
    rd(6'h00, d); check("R2 en0", d, 32'h0001_0001);
    rd(6'h08, d); check("R2 en1", d, 32'hFFFF_FFFF);
    rd(6'h24, d); check("R7 wake1 masked", d, 32'h0000_FFFF);
    wr(6'h10, 32'hFFFF_FFFF);
    rd(6'h10, d); check("R2 word2 absent", d, 32'h0);
    rd(6'h28, d); check("R2 wake2 absent", d, 32'h0);
    rd(6'h30, d); check("R2 hole", d, 32'h0);
    rd(6'h02, d); check("R2 misaligned", d, 32'h0);

    // R3 live status, writes ignored
    @(negedge clk) src_level = {32'hA5A5_0000, 32'h1234_5678};
    rd(6'h04, d); check("R3 status0", d, 32'h1234_5678);
    wr(6'h04, 32'h0);
    rd(6'h04, d); check("R3 status0 after write", d, 32'h1234_5678);
    rd(6'h0C, d); check("R3 status1", d, 32'hA5A5_0000);
    rd(6'h00, d); check("R3 en0 untouched", d, 32'h0001_0001);
    @(negedge clk) src_level = '0;
    @(negedge clk);
    @(negedge clk);

    // Table walk: R4 latency, R5 routing, R6 unused, R8 suspend
    prev = parent_irq;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      src_level = {VECS[i].w1, VECS[i].w0};
      suspend   = VECS[i].susp;
      #1 check($sformatf("R4 hold before edge v%0d", i), 32'(parent_irq), 32'(prev));
      @(negedge clk);
      check($sformatf("R%0d vector %0d", VECS[i].req, i), 32'(parent_irq), 32'(VECS[i].exp));
      prev = VECS[i].exp;
    end

    // R8 stored enable reads back unchanged under suspend
    rd(6'h00, d); check("R8 en0 under suspend", d, 32'h0001_0001);
    @(negedge clk) suspend = 1'b0; src_level = {32'h0, 32'h0000_0002};
    @(negedge clk); check("R8 after suspend drop", 32'(parent_irq), 32'h0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule